// File: doc/BRIEF.md
# Sample Word-Length and Format Adapter

This block sits on a streaming audio sample path between a sample-rate converter and a bus data port. Each 32-bit sample that comes in on a valid/ready stream is shortened to a word length of 16, 20 or 24 bits. The length is chosen from a data-length configuration field counted in slots. The new least-significant bit of the shortened sample carries one dither bit, taken from an internal pseudo-random generator. Output samples are left-aligned in the 32-bit word and every bit below the chosen length is zero.

A data-type field selects how samples are coded on the bus side: two's complement or sign-magnitude. A direction input says which side of the block faces the bus. Toward the bus, two's complement input is shortened and then coded as sign-magnitude. From the bus, sign-magnitude input is first decoded to two's complement and then shortened. Shortening always happens in the two's complement domain.

When the converter-enable input is low, the sample keeps its full width and gets no dither. The coding conversion still applies. The path has a single register stage and follows output backpressure.

Top module: `wla_adapter`

## Requirements
- R1: With the converter enabled, a data-length value of 1, 2, 3 or 4 gives a 16-bit result: out_data[15:0] is zero except the dither bit at bit 16, and bits 31:17 come from the sample.
- R2: With the converter enabled, a data-length value of 5 gives a 20-bit result: out_data[11:0] is zero and bit 12 holds the dither bit.
- R3: With the converter enabled, a data-length value of 0 (not indicated) or any value of 6 and above gives a 24-bit result: out_data[7:0] is zero and bit 8 holds the dither bit.
- R4: With cfg_en low, cfg_dl has no effect: no bit is cleared, no dither is inserted, and the 32-bit sample passes at full width, apart from any coding conversion.
- R5: The dither bit is bit 0 of a 16-bit LFSR. Its seed after reset is 0xACE1. It shifts left once per accepted input sample, and the new bit 0 is the XOR of bits 15, 14, 12 and 3. The bit in use for a sample is the value the LFSR holds before that sample's shift.
- R6: Shortening drops the low bits of the two's complement value (rounding toward minus infinity), then sets the new least-significant bit to the dither bit.
- R7: A cfg_dt value other than 1 leaves the coding as two's complement in both directions.
- R8: With cfg_dt = 1 and cfg_to_bus = 1, the shortened two's complement value goes out as sign-magnitude: bit 31 is the sign and bits 30:0 are the magnitude, left-aligned.
- R9: With cfg_dt = 1 and cfg_to_bus = 0, the input is read as sign-magnitude (bit 31 sign, bits 30:0 magnitude) and converted to two's complement before shortening. Negative zero becomes zero.
- R10: Toward the bus in sign-magnitude coding, the most negative two's complement value 0x80000000 saturates to sign 1 with all magnitude bits of the active length set (0xFFFF0000 at 16 bits, 0xFFFFFFFF at full width).
- R11: A sample accepted on a rising edge appears on out_data with out_valid high right after that edge.
- R12: in_ready equals !out_valid || out_ready. While out_valid is high and out_ready is low, out_valid and out_data hold, and no sample is lost.
- R13: Asynchronous reset clears out_valid and reloads the LFSR seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Converter in use: enables shortening and dither |
| cfg_dl | input | DL_W (6) | Data length in slots; 0 means not indicated |
| cfg_dt | input | DT_W (4) | Data type; 1 selects sign-magnitude bus coding |
| cfg_to_bus | input | 1 | 1: input is two's complement, output is bus coding; 0: the reverse |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample can be accepted |
| in_data | input | DATA_W (32) | Input sample |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream can take the output |
| out_data | output | DATA_W (32) | Output sample, left-aligned |

## Verification
Some properties are checked on every cycle: the cleared low bits for each data-length class, the one-cycle step from acceptance to output valid, and the holding of the output under backpressure. Readiness whenever the output register is empty is also checked every cycle. The exact dither sequence, the coding conversions with negative zero and most-negative saturation, the full-width bypass when disabled, and the LFSR restart after a reset only show up in the bench scenarios. There, the bench compares outputs against a reference model and a model of the LFSR.

// File: rtl/wla_pkg.sv
package wla_pkg;

  typedef enum logic [1:0] {
    WL_16   = 2'd0,
    WL_20   = 2'd1,
    WL_24   = 2'd2,
    WL_FULL = 2'd3
  } wl_sel_e;

  localparam int SHORT_LEN       = 16;
  localparam int MID_LEN         = 20;
  localparam int LONG_LEN        = 24;
  localparam int SLOTS_SHORT_MAX = 4;
  localparam int SLOTS_MID       = 5;
  localparam int DL_UNSPECIFIED  = 0;
  localparam int DT_SIGN_MAG     = 1;

endpackage

// File: rtl/wla_len_decode.sv
module wla_len_decode
  import wla_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DL_W   = 6
) (
  input  logic              enable,
  input  logic [DL_W-1:0]   dl,
  output wl_sel_e           sel,
  output logic [DATA_W-1:0] keep_mask,
  output logic [DATA_W-1:0] lsb_onehot
);

  localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] ONE      = {{(DATA_W-1){1'b0}}, 1'b1};

  int unsigned dl_val;
  int          width;

  always_comb begin
    dl_val = int'(dl);
    if (!enable) begin
      sel = WL_FULL;
    end else if (dl_val == DL_UNSPECIFIED) begin
      sel = WL_24;
    end else if (dl_val <= SLOTS_SHORT_MAX) begin
      sel = WL_16;
    end else if (dl_val == SLOTS_MID) begin
      sel = WL_20;
    end else begin
      sel = WL_24;
    end
  end

  always_comb begin
    case (sel)
      WL_16:   width = SHORT_LEN;
      WL_20:   width = MID_LEN;
      WL_24:   width = LONG_LEN;
      default: width = DATA_W;
    endcase
    keep_mask = ALL_ONES << (DATA_W - width);
    if (sel == WL_FULL) begin
      lsb_onehot = '0;
    end else begin
      lsb_onehot = ONE << (DATA_W - width);
    end
  end

endmodule

// File: rtl/wla_lfsr.sv
module wla_lfsr #(
  parameter int               W    = 16,
  parameter logic [W-1:0]     TAPS = 16'hD008,
  parameter logic [W-1:0]     SEED = 16'hACE1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic advance,
  output logic bit_out
);

  logic [W-1:0] state_q;
  logic [W-1:0] state_d;
  logic         feedback;

  always_comb begin
    feedback = ^(state_q & TAPS);
    if (advance) begin
      state_d = {state_q[W-2:0], feedback};
    end else begin
      state_d = state_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEED;
    end else begin
      state_q <= state_d;
    end
  end

  assign bit_out = state_q[0];

endmodule

// File: rtl/wla_shape.sv
module wla_shape #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] sample_in,
  input  logic [DATA_W-1:0] keep_mask,
  input  logic [DATA_W-1:0] lsb_onehot,
  input  logic              dither,
  input  logic              sm_coding,
  input  logic              to_bus,
  output logic [DATA_W-1:0] sample_out
);

  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] magnitude;
  logic [DATA_W-1:0] decoded;
  logic [DATA_W-1:0] shortened;
  logic [DATA_W-1:0] negated;

  // Stage 1: bus coding into two's complement when reading from the bus
  always_comb begin
    magnitude = {1'b0, sample_in[DATA_W-2:0]};
    if (sm_coding && !to_bus) begin
      decoded = sample_in[DATA_W-1] ? (~magnitude + 1'b1) : magnitude;
    end else begin
      decoded = sample_in;
    end
  end

  // Stage 2: drop low bits, place dither at the new least-significant bit
  always_comb begin
    shortened = decoded & keep_mask & ~lsb_onehot;
    if (dither) begin
      shortened = shortened | lsb_onehot;
    end
  end

  // Stage 3: two's complement into bus coding when writing to the bus
  always_comb begin
    negated = ~shortened + 1'b1;
    if (sm_coding && to_bus) begin
      if (shortened == MOST_NEG) begin
        sample_out = keep_mask;
      end else if (shortened[DATA_W-1]) begin
        sample_out = {1'b1, negated[DATA_W-2:0]};
      end else begin
        sample_out = shortened;
      end
    end else begin
      sample_out = shortened;
    end
  end

endmodule

// File: rtl/wla_adapter.sv
module wla_adapter
  import wla_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter int                DL_W      = 6,
  parameter int                DT_W      = 4,
  parameter int                LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hD008,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic [DL_W-1:0]   cfg_dl,
  input  logic [DT_W-1:0]   cfg_dt,
  input  logic              cfg_to_bus,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);

  localparam logic [DT_W-1:0] DT_SM_CODE = DT_W'(DT_SIGN_MAG);

  wl_sel_e           len_sel;
  logic [DATA_W-1:0] keep_mask;
  logic [DATA_W-1:0] lsb_onehot;
  logic              dither_bit;
  logic              sm_coding;
  logic              accept;
  logic [DATA_W-1:0] shaped;

  logic              valid_q;
  logic              valid_d;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] data_d;
  logic              data_en;

  assign sm_coding = (cfg_dt == DT_SM_CODE);
  assign in_ready  = !valid_q || out_ready;
  assign accept    = in_valid && in_ready;

  wla_len_decode #(
    .DATA_W (DATA_W),
    .DL_W   (DL_W)
  ) i_len_decode (
    .enable     (cfg_en),
    .dl         (cfg_dl),
    .sel        (len_sel),
    .keep_mask  (keep_mask),
    .lsb_onehot (lsb_onehot)
  );

  wla_lfsr #(
    .W    (LFSR_W),
    .TAPS (LFSR_TAPS),
    .SEED (LFSR_SEED)
  ) i_lfsr (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (accept),
    .bit_out (dither_bit)
  );

  wla_shape #(
    .DATA_W (DATA_W)
  ) i_shape (
    .sample_in  (in_data),
    .keep_mask  (keep_mask),
    .lsb_onehot (lsb_onehot),
    .dither     (dither_bit),
    .sm_coding  (sm_coding),
    .to_bus     (cfg_to_bus),
    .sample_out (shaped)
  );

  always_comb begin
    data_en = accept;
    data_d  = shaped;
    if (accept) begin
      valid_d = 1'b1;
    end else if (out_ready) begin
      valid_d = 1'b0;
    end else begin
      valid_d = valid_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= data_d;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;

  // len_sel is kept for visibility of the decoded class in debug
  logic unused_sel;
  assign unused_sel = ^len_sel;

endmodule

// File: rtl/wla_adapter_chk.sv
module wla_adapter_chk #(
  parameter int DATA_W = 32,
  parameter int DL_W   = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_en,
  input logic [DL_W-1:0]   cfg_dl,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data
);

  logic dl_short;
  logic dl_mid;
  logic dl_long;

  assign dl_short = (int'(cfg_dl) >= 1) && (int'(cfg_dl) <= 4);
  assign dl_mid   = (int'(cfg_dl) == 5);
  assign dl_long  = (int'(cfg_dl) == 0) || (int'(cfg_dl) >= 6);

  a_r1_short_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cfg_en && dl_short |-> out_data[DATA_W-17:0] == '0);

  a_r2_mid_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cfg_en && dl_mid |-> out_data[DATA_W-21:0] == '0);

  a_r3_long_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cfg_en && dl_long |-> out_data[DATA_W-25:0] == '0);

  a_r11_accept_to_valid: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  a_r12_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  a_r12_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

endmodule

bind wla_adapter wla_adapter_chk #(
  .DATA_W (DATA_W),
  .DL_W   (DL_W)
) i_wla_adapter_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_en    (cfg_en),
  .cfg_dl    (cfg_dl),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/test_wla_adapter.sv
module test_wla_adapter;

  logic        clk;
  logic        rst_n;
  logic        cfg_en;
  logic [5:0]  cfg_dl;
  logic [3:0]  cfg_dt;
  logic        cfg_to_bus;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_data;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_data;

  int checks;
  int failures;
  bit finished;
  logic [15:0] m_lfsr;

  typedef struct packed {
    logic        en;
    logic [5:0]  dl;
    logic [3:0]  dt;
    logic        tobus;
    logic [31:0] data;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 6'd4,  4'd0, 1'b1, 32'h12345678},  // R1
    '{1'b1, 6'd1,  4'd0, 1'b1, 32'h7FFFFFFF},  // R1
    '{1'b1, 6'd3,  4'd0, 1'b1, 32'hFFFFFFFF},  // R6
    '{1'b1, 6'd5,  4'd0, 1'b1, 32'hDEADBEEF},  // R2
    '{1'b1, 6'd6,  4'd0, 1'b1, 32'h00000000},  // R3
    '{1'b1, 6'd0,  4'd0, 1'b1, 32'hCAFEF00D},  // R3
    '{1'b1, 6'd63, 4'd0, 1'b1, 32'h0F0F0F0F},  // R3
    '{1'b0, 6'd9,  4'd0, 1'b1, 32'h89ABCDEF},  // R4
    '{1'b1, 6'd4,  4'd1, 1'b1, 32'hFFFF8000},  // R8
    '{1'b1, 6'd4,  4'd1, 1'b1, 32'h80000000},  // R10
    '{1'b0, 6'd0,  4'd1, 1'b1, 32'h80000000},  // R10
    '{1'b1, 6'd5,  4'd1, 1'b0, 32'h80001234},  // R9
    '{1'b1, 6'd4,  4'd1, 1'b0, 32'h80000000},  // R9
    '{1'b1, 6'd6,  4'd2, 1'b0, 32'h80000000},  // R7
    '{1'b0, 6'd2,  4'd0, 1'b0, 32'h00000001},  // R4
    '{1'b1, 6'd5,  4'd1, 1'b1, 32'h00ABCDEF}   // R8
  };

  function automatic string tag_of(int i);
    case (i)
      0, 1:    return "R1";
      2:       return "R6";
      3:       return "R2";
      4, 5, 6: return "R3";
      7, 14:   return "R4";
      8, 15:   return "R8";
      9, 10:   return "R10";
      11, 12:  return "R9";
      default: return "R7";
    endcase
  endfunction

  function automatic logic [31:0] ref_out(logic en, logic [5:0] dl, logic [3:0] dt,
                                          logic tobus, logic [31:0] x, logic d);
    int w;
    logic [31:0] v;
    logic [31:0] mask;
    logic [31:0] neg;
    logic sm;
    sm = (dt == 4'd1);
    if (!en) w = 32;
    else if (dl == 6'd0) w = 24;
    else if (dl <= 6'd4) w = 16;
    else if (dl == 6'd5) w = 20;
    else w = 24;
    v = x;
    if (!tobus && sm) begin
      v = {1'b0, x[30:0]};
      if (x[31]) v = -v;
    end
    mask = 32'hFFFFFFFF << (32 - w);
    if (w < 32) begin
      v = v & mask;
      v[32-w] = d;
    end
    if (tobus && sm) begin
      if (v == 32'h80000000) v = mask;
      else if (v[31]) begin
        neg = -v;
        v = {1'b1, neg[30:0]};
      end
    end
    return v;
  endfunction

  function automatic logic [15:0] lfsr_next(logic [15:0] s);
    return {s[14:0], s[15] ^ s[14] ^ s[12] ^ s[3]};
  endfunction

  wla_adapter i_wla_adapter (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_en     (cfg_en),
    .cfg_dl     (cfg_dl),
    .cfg_dt     (cfg_dt),
    .cfg_to_bus (cfg_to_bus),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    m_lfsr = 16'hACE1;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_one(logic en, logic [5:0] dl, logic [3:0] dt, logic tobus,
                          logic [31:0] x, string tag);
    logic [31:0] exp;
    cfg_en = en; cfg_dl = dl; cfg_dt = dt; cfg_to_bus = tobus;
    in_data = x; in_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk);
    exp = ref_out(en, dl, dt, tobus, x, m_lfsr[0]);
    m_lfsr = lfsr_next(m_lfsr);
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, {31'd0, out_valid}, 32'd1);
    check(tag, out_data, exp);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp_a;
    logic [31:0] exp_b;
    checks = 0; failures = 0; finished = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b1;
    cfg_en = 1'b0; cfg_dl = '0; cfg_dt = '0; cfg_to_bus = 1'b1;
    m_lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13: reset state
    check("R13", {31'd0, out_valid}, 32'd0);
    check("R12", {31'd0, in_ready}, 32'd1);
    // R5: first dither after reset is seed bit 0 (1) at bit 16
    send_one(1'b1, 6'd4, 4'd0, 1'b1, 32'h00000000, "R5");

    for (int i = 0; i < NVEC; i++) begin
      send_one(VECS[i].en, VECS[i].dl, VECS[i].dt, VECS[i].tobus, VECS[i].data, tag_of(i));
    end

    // R5: a run of zero samples exposes the dither sequence at bit 8
    for (int k = 0; k < 8; k++) begin
      send_one(1'b1, 6'd6, 4'd0, 1'b1, 32'h00000000, "R5");
    end

    // R4: disabled path ignores two different data lengths
    send_one(1'b0, 6'd4, 4'd0, 1'b1, 32'h13579BDF, "R4");
    send_one(1'b0, 6'd5, 4'd0, 1'b1, 32'h13579BDF, "R4");

    // R12: backpressure holds output and loses nothing
    cfg_en = 1'b1; cfg_dl = 6'd4; cfg_dt = 4'd0; cfg_to_bus = 1'b1;
    out_ready = 1'b0; in_valid = 1'b1; in_data = 32'hAAAA5555;
    @(posedge clk);
    exp_a = ref_out(1'b1, 6'd4, 4'd0, 1'b1, 32'hAAAA5555, m_lfsr[0]);
    m_lfsr = lfsr_next(m_lfsr);
    @(negedge clk);
    in_data = 32'h5555AAAA;
    check("R11", {31'd0, out_valid}, 32'd1);
    check("R12", out_data, exp_a);
    check("R12", {31'd0, in_ready}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    check("R12", out_data, exp_a);
    check("R12", {31'd0, out_valid}, 32'd1);
    out_ready = 1'b1;
    @(posedge clk);
    exp_b = ref_out(1'b1, 6'd4, 4'd0, 1'b1, 32'h5555AAAA, m_lfsr[0]);
    m_lfsr = lfsr_next(m_lfsr);
    @(negedge clk);
    in_valid = 1'b0;
    check("R12", out_data, exp_b);
    @(posedge clk);
    @(negedge clk);
    check("R12", {31'd0, out_valid}, 32'd0);

    // R13: reset mid-run restarts the LFSR at its seed
    send_one(1'b1, 6'd4, 4'd0, 1'b1, 32'h00000000, "R5");
    do_reset();
    check("R13", {31'd0, out_valid}, 32'd0);
    send_one(1'b1, 6'd4, 4'd0, 1'b1, 32'h00000000, "R13");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule